// File: doc/BRIEF.md
# SPI Mode-0 Command Frame Decoder

This block is the slave side of a serial control port. A host selects it by pulling the active-low chip select low. The host then clocks in exactly three bytes on the data input, most significant bit first. The first byte is a fixed identification value. The second byte carries an opcode and a register address. The third byte is either write data or a dummy byte, and during a dummy byte the block shifts the addressed register out on the data output. The block oversamples the serial pins with its own system clock through a synchronizer. Its whole internal state therefore sits in one clock domain.

Toward the chip, the block exposes a small register-bank port: an address, a one-cycle write strobe, write data, a read-data input and an end-of-frame pulse. A frame is discarded without side effects when any of these hold: the identification byte is wrong, the opcode is not one of the two legal ones, the address is not one of the two supported registers, or the frame length is not exactly 24 bits. The register storage itself lives outside this block.

Top module: `spi_frame_decoder`

## Requirements
- R1: The block works in SPI mode 0 only. The data input is captured on rising serial-clock edges, and the data output changes only after falling serial-clock edges.
- R2: A falling edge on the chip select clears all progress. Bits received in an earlier chip-select period do not count toward the new frame.
- R3: Every byte is transferred most significant bit first, in both directions.
- R4: The first byte must equal 8'h50. Any other value makes the block ignore the frame: no write is issued and the data output stays 0.
- R5: In the second byte, bits [3:2] must be 0 and bits [1:0] are the address. Address 2'b00 selects the wiper register and 2'b10 selects the control register. Any other bit pattern in bits [3:0] makes the block ignore the frame.
- R6: The opcode is bits [7:4] of the second byte. 4'b1011 means read and 4'b1100 means write. Any other opcode makes the block ignore the frame.
- R7: In a read, the value presented on the read-data input for the decoded address is shifted out during the third byte. Its bit 7 is valid before the first rising serial-clock edge of that byte.
- R8: An accepted write produces exactly one single-cycle write strobe. It occurs in the cycle the chip-select rise is detected, with the decoded address and the third byte on the bank port.
- R9: A write frame of any length other than exactly 24 bits produces no write strobe.
- R10: The data output is 0 in each of these cases: while chip select is high, during the first two bytes, and for any ignored frame.
- R11: Every detected chip-select rise produces a one-cycle end-of-frame pulse, whether or not the frame was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | 2 | Decoded register address |
| reg_wr | output | 1 | One-cycle write strobe to the register bank |
| reg_wdata | output | 8 | Write data to the register bank |
| reg_rdata | input | 8 | Read data from the register bank for reg_addr |
| frame_end | output | 1 | One-cycle pulse on each chip-select rise |

## Verification
The bench builds the decoder with the default two synchronizer stages and drives the serial clock with a half period of six system clocks. That half period leaves room for the synchronizer latency plus the output register, so the response bit settles before the host samples it. Because of this, read data can be compared bit by bit on the host side of the link. Random frames mix corrupted identification bytes, illegal opcodes, illegal address and reserved bits, and lengths from 20 to 28 bits with legal traffic. This reaches every rejection path and both the short-frame and long-frame write-drop cases.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 3;
    localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
    localparam int ADDR_W      = 2;
    localparam int CNT_W       = $clog2(FRAME_BITS + 1) + 1;
    localparam int LSB_W       = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] ID_VALUE   = 8'h50;
    localparam logic [3:0]        OPC_READ   = 4'b1011;
    localparam logic [3:0]        OPC_WRITE  = 4'b1100;
    localparam logic [ADDR_W-1:0] ADDR_WIPER = 2'b00;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'b10;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } access_e;

    typedef struct packed {
        access_e           kind;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    function automatic logic id_ok(input logic [BYTE_W-1:0] b);
        return b == ID_VALUE;
    endfunction

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.addr = b[ADDR_W-1:0];
        c.kind = ACC_NONE;
        if (b[3:2] == 2'b00 && (c.addr == ADDR_WIPER || c.addr == ADDR_CTRL)) begin
            if (b[7:4] == OPC_READ)       c.kind = ACC_READ;
            else if (b[7:4] == OPC_WRITE) c.kind = ACC_WRITE;
        end
        return c;
    endfunction

endpackage

// File: rtl/sfd_sync.sv
module sfd_sync #(
    parameter int              STAGES  = 2,
    parameter int              W       = 3,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= g_stg[s-1].q;
            end
        end
    end

    assign level = g_stg[STAGES-1].q;

endmodule

// File: rtl/sfd_edge.sv
module sfd_edge #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;

endmodule

// File: rtl/sfd_rx.sv
module sfd_rx
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              mosi,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              byte_strobe
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS);
    localparam logic [LSB_W-1:0] BIT_TOP  = '1;

    always_ff @(posedge clk) begin
        if (rst || cs_fall) begin
            bit_cnt     <= '0;
            rx_byte     <= '0;
            byte_strobe <= 1'b0;
        end else begin
            byte_strobe <= 1'b0;
            if (cs_low && sck_rise) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], mosi};
                if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt[LSB_W-1:0] == BIT_TOP && bit_cnt < CNT_LAST)
                    byte_strobe <= 1'b1;
            end
        end
    end

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> (bit_cnt == '0));  // R2
    AST_STROBE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        byte_strobe |-> (bit_cnt[LSB_W-1:0] == '0 && bit_cnt != '0 && bit_cnt <= CNT_LAST));  // R1

endmodule

// File: rtl/sfd_ctrl.sv
module sfd_ctrl
    import sfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_fall,
    input  logic [CNT_W-1:0]  bit_cnt,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              byte_strobe,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              frame_end,
    output logic              miso
);

    localparam logic [CNT_W-1:0] CNT_ID   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] RD_FIRST = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(FRAME_BITS - 1);

    logic              reject;
    cmd_t              cmd;
    cmd_t              cmd_dec;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] tx_src;
    logic [LSB_W-1:0]  tx_sel;
    logic              in_rd_byte;

    assign cmd_dec    = decode_cmd(rx_byte);
    assign in_rd_byte = (bit_cnt >= RD_FIRST) && (bit_cnt <= RD_LAST);
    assign tx_src     = (bit_cnt == RD_FIRST) ? reg_rdata : tx;
    assign tx_sel     = ~bit_cnt[LSB_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            reject    <= 1'b0;
            cmd       <= '{kind: ACC_NONE, addr: '0};
            wdata     <= '0;
            tx        <= '0;
            miso      <= 1'b0;
            reg_wr    <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            reg_wr    <= 1'b0;
            frame_end <= 1'b0;
            if (cs_fall) begin
                reject <= 1'b0;
                cmd    <= '{kind: ACC_NONE, addr: '0};
                miso   <= 1'b0;
            end else begin
                if (byte_strobe) begin
                    if (bit_cnt == CNT_ID) begin
                        if (!id_ok(rx_byte)) reject <= 1'b1;
                    end else if (bit_cnt == CNT_CMD) begin
                        if (!reject) begin
                            cmd <= cmd_dec;
                            if (cmd_dec.kind == ACC_NONE) reject <= 1'b1;
                        end
                    end else if (bit_cnt == CNT_DATA) begin
                        wdata <= rx_byte;
                    end
                end
                if (sck_fall) begin
                    if (!reject && cmd.kind == ACC_READ && in_rd_byte) begin
                        if (bit_cnt == RD_FIRST) tx <= reg_rdata;
                        miso <= tx_src[tx_sel];
                    end else begin
                        miso <= 1'b0;
                    end
                end
                if (!cs_low) miso <= 1'b0;
                if (cs_rise) begin
                    frame_end <= 1'b1;
                    if (!reject && cmd.kind == ACC_WRITE && bit_cnt == CNT_DATA)
                        reg_wr <= 1'b1;
                end
            end
        end
    end

    assign reg_addr  = cmd.addr;
    assign reg_wdata = wdata;

    AST_WR_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> frame_end);  // R8
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);  // R8
    AST_WR_LEGAL_ADDR: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> (reg_addr == ADDR_WIPER || reg_addr == ADDR_CTRL));  // R5
    AST_END_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> !frame_end);  // R11
    AST_MISO_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !cs_low |=> !miso);  // R10
    AST_MISO_QUIET_EARLY: assert property (@(posedge clk) disable iff (rst)
        (cs_low && bit_cnt < RD_FIRST) |=> !miso);  // R10

endmodule

// File: rtl/spi_frame_decoder.sv
module spi_frame_decoder
    import sfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              frame_end
);

    localparam int PIN_W = 3;

    logic [PIN_W-1:0]  pins_s;
    logic [1:0]        ev_rise;
    logic [1:0]        ev_fall;
    logic              cs_n_s;
    logic              sck_s;
    logic              mosi_s;
    logic              cs_low;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_byte;
    logic              byte_strobe;

    sfd_sync #(
        .STAGES (SYNC_STAGES),
        .W      (PIN_W),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({spi_cs_n, spi_sck, spi_mosi}),
        .level(pins_s)
    );

    assign {cs_n_s, sck_s, mosi_s} = pins_s;
    assign cs_low = ~cs_n_s;

    sfd_edge #(
        .W      (2),
        .RST_VAL(2'b10)
    ) u_edge (
        .clk (clk),
        .rst (rst),
        .lvl ({cs_n_s, sck_s}),
        .rise(ev_rise),
        .fall(ev_fall)
    );

    sfd_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .cs_low     (cs_low),
        .cs_fall    (ev_fall[1]),
        .sck_rise   (ev_rise[0]),
        .mosi       (mosi_s),
        .bit_cnt    (bit_cnt),
        .rx_byte    (rx_byte),
        .byte_strobe(byte_strobe)
    );

    sfd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_low     (cs_low),
        .cs_fall    (ev_fall[1]),
        .cs_rise    (ev_rise[1]),
        .sck_fall   (ev_fall[0]),
        .bit_cnt    (bit_cnt),
        .rx_byte    (rx_byte),
        .byte_strobe(byte_strobe),
        .reg_rdata  (reg_rdata),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .frame_end  (frame_end),
        .miso       (spi_miso)
    );

endmodule

// File: tb/spi_frame_decoder_tb.sv
`timescale 1ns/1ps
module spi_frame_decoder_tb;

    localparam int HP = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [1:0] reg_addr;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       frame_end;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] bank_w = 8'h3C, bank_c = 8'h40;
    logic [7:0] exp_w  = 8'h3C, exp_c  = 8'h40;
    int         wr_cnt = 0, fe_cnt = 0;
    logic [1:0] last_addr = '0;
    logic [7:0] last_data = '0;

    always #2.5 clk = ~clk;

    spi_frame_decoder u_dut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_end(frame_end)
    );

    assign reg_rdata = (reg_addr == 2'b10) ? bank_c : bank_w;

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= reg_addr;
            last_data <= reg_wdata;
            if (reg_addr == 2'b10) bank_c <= reg_wdata;
            else                   bank_w <= reg_wdata;
        end
        if (frame_end) fe_cnt <= fe_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit frame_ok(input logic [7:0] b1, input logic [7:0] b2);
        return b1 == 8'h50 && b2[3:2] == 2'b00 && (b2[1:0] == 2'b00 || b2[1:0] == 2'b10)
            && (b2[7:4] == 4'b1011 || b2[7:4] == 4'b1100);
    endfunction

    function automatic string why_tag(input logic [7:0] b1, input logic [7:0] b2, input int nbits);
        if (b1 != 8'h50) return "R4";
        if (b2[7:4] != 4'b1011 && b2[7:4] != 4'b1100) return "R6";
        if (b2[3:2] != 2'b00 || b2[1] != b2[0] && b2[0]) return "R5";
        if (b2[1:0] == 2'b01 || b2[1:0] == 2'b11) return "R5";
        if (nbits != 24) return "R9";
        return "R8";
    endfunction

    task automatic run_frame(input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3, input int nbits);
        logic [23:0] word = {b1, b2, b3};
        logic [7:0]  rx = '0;
        int          wr0 = wr_cnt;
        int          fe0 = fe_cnt;
        bit          quiet = 1;
        bit          ok = frame_ok(b1, b2);
        bit          exp_wr = ok && b2[7:4] == 4'b1100 && nbits == 24;
        bit          is_rd = ok && b2[7:4] == 4'b1011;
        logic [7:0]  exp_rd = (b2[1:0] == 2'b10) ? exp_c : exp_w;
        string       tag = why_tag(b1, b2, nbits);
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? word[23-i] : 1'($urandom);
            repeat (HP) @(negedge clk);
            if (i >= 16 && i < 24) rx[23-i] = miso;
            else if (miso !== 1'b0) quiet = 0;
            sck = 1'b1;
            repeat (HP) @(negedge clk);
            sck = 1'b0;
        end
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        check(fe_cnt == fe0 + 1, "R11 end pulse count", fe_cnt - fe0, 1);
        check(wr_cnt == wr0 + int'(exp_wr), {tag, " write count"}, wr_cnt - wr0, int'(exp_wr));
        if (exp_wr) begin
            check(last_addr == b2[1:0] && last_data == b3, "R8 write addr/data",
                  {last_addr, last_data}, {b2[1:0], b3});
            if (b2[1:0] == 2'b10) exp_c = b3; else exp_w = b3;
        end
        if (nbits >= 24) begin
            if (is_rd) check(rx == exp_rd, "R1 R3 R7 read data", rx, exp_rd);
            else       check(rx == 8'h00, {tag, " R10 quiet sdo"}, rx, 0);
        end
        check(quiet, "R10 sdo outside read byte", !quiet, 0);
        check(miso === 1'b0, "R10 sdo idle", miso, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(miso === 1'b0 && reg_wr === 1'b0 && frame_end === 1'b0, "R10 reset state",
              {miso, reg_wr, frame_end}, 0);

        // R8 write wiper, R3/R7 read it back with an asymmetric value
        run_frame(8'h50, 8'hC0, 8'hA6, 24);
        run_frame(8'h50, 8'hB0, 8'h00, 24);
        run_frame(8'h50, 8'hC2, 8'h81, 24);
        run_frame(8'h50, 8'hB2, 8'hFF, 24);
        // R4 bad identification
        run_frame(8'h51, 8'hC0, 8'h11, 24);
        run_frame(8'hD0, 8'hB0, 8'h00, 24);
        // R6 bad opcode
        run_frame(8'h50, 8'hD0, 8'h22, 24);
        // R5 unsupported address and reserved bits
        run_frame(8'h50, 8'hC1, 8'h33, 24);
        run_frame(8'h50, 8'hC4, 8'h44, 24);
        run_frame(8'h50, 8'hB3, 8'h00, 24);
        // R9 short and long write frames
        run_frame(8'h50, 8'hC0, 8'h55, 23);
        run_frame(8'h50, 8'hC0, 8'h66, 25);
        // R2 aborted partial frame then a clean write
        run_frame(8'h50, 8'hC0, 8'h77, 10);
        run_frame(8'h50, 8'hC0, 8'h5A, 24);
        run_frame(8'h50, 8'hB0, 8'h00, 24);

        for (int k = 0; k < 80; k++) begin
            logic [7:0] b1, b2, b3;
            int nb;
            b1 = ($urandom % 6 == 0) ? 8'($urandom) : 8'h50;
            case ($urandom % 5)
                0, 1:    b2[7:4] = 4'b1100;
                2, 3:    b2[7:4] = 4'b1011;
                default: b2[7:4] = 4'($urandom);
            endcase
            b2[3:2] = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
            case ($urandom % 5)
                0, 1:    b2[1:0] = 2'b00;
                2, 3:    b2[1:0] = 2'b10;
                default: b2[1:0] = 2'($urandom);
            endcase
            b3 = 8'($urandom);
            nb = ($urandom % 6 == 0) ? 20 + int'($urandom % 9) : 24;
            run_frame(b1, b2, b3, nb);
        end
        done = 1;
        finish_run();
    end

endmodule